// File: doc/BRIEF.md
# Host Serial Readout Port for an Eight-Channel Word Receiver Array

This block is the host-facing serial slave that sits in front of up to eight receive channels, each of which holds 32-bit bus words in a small queue. A host microcontroller talks to it over a four-wire SPI link. A frame begins when chip select goes low. The host first sends an 8-bit command byte. The upper five bits of that byte pick the operation and the lower three bits pick the channel. The block then returns data on the serial output, or it takes a second byte that sets the control state.

When the host reads a word, the block takes it from the selected channel. It reorders the bits on the way out: the 24 data bits go first, from the most significant bit downward, and the 8 label bits go last. A control bit chooses whether the label bits come out in normal or reversed order. The word leaves the queue only after the host has clocked out all 32 bits, so a frame that is cut short loses nothing.

The block also has a global flag that combines the flags of all channels. The serial pins are oversampled by the block's own clock, so the whole design runs in one clock domain.

Top module: `spi_word_reader`

## Requirements
- R1: `spi_so_oe` is 1 only while the synchronised chip select is low, and `spi_so` is 0 whenever `spi_so_oe` is 0. Both are 0 after reset.
- R2: Mode 0 framing. SI is sampled on SCK rising edges and SO changes on SCK falling edges, MSB first. Command byte bits [7:3] are the operation (00001 read word, 00010 read status, 00011 write control) and bits [2:0] are the channel number.
- R3: In a read word, with channel word bit k holding bus bit k+1, serial positions 1..24 carry word bits 31 down to 8.
- R4: With the label-order control bit at 0, serial positions 25..32 carry word bits 0,1,...,7 in that order.
- R5: With the label-order control bit at 1, serial positions 25..32 carry word bits 7,6,...,0 in that order.
- R6: `flag_any` equals the OR of all bits of `ch_flag` at all times.
- R7: A read word gives exactly one single-cycle pulse on `ch_pop`, and only for the selected channel, after the 32nd data bit's rising SCK. If chip select rises before that edge, there is no pulse.
- R8: A read word from an empty channel returns 32 zeros and produces no pop.
- R9: A write control frame sets the label-order bit from bit 0 of the second byte on that byte's 8th rising SCK. The bit is 0 after reset. A write frame that ends before 16 rising edges leaves it unchanged.
- R10: A read status returns one byte, `ch_flag[7]` first down to `ch_flag[0]`, as captured at the command byte.
- R11: An unknown operation code returns zeros on SO, pops nothing and leaves the control bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for the SO pad driver (pad floats when 0) |
| ch_rd_data | input | N_CH*32 | Head word of each channel queue, channel i at bits [32i+31:32i] |
| ch_empty | input | N_CH | Queue-empty indication per channel |
| ch_flag | input | N_CH | Per-channel flag |
| ch_pop | output | N_CH | One-cycle pop strobe per channel |
| flag_any | output | 1 | OR of all channel flags |

## Verification
Every serial pin passes through a two-stage synchroniser and then an edge register. As a result, `spi_so_oe` follows chip select after 2 clocks, and SO, `ch_pop` and the control bit update on the 3rd clock edge after an SCK transition. The bench holds each SCK phase for 8 clocks and samples SO on the falling clock edge just before it raises SCK, so every bit has settled well before it is read. Pop counts and control effects are checked only after the frame gap has passed. The output-enable check uses a two-entry history of chip select, so the 2-clock delay is modelled exactly. `flag_any` is compared on every clock with no delay.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int WORD_W       = 32;
  localparam int LBL_W        = 8;
  localparam int OP_W         = 8;
  localparam int CH_SEL_W     = 3;
  localparam int CODE_W       = OP_W - CH_SEL_W;
  localparam int CTRL_REV_BIT = 0;

  localparam logic [CODE_W-1:0] CODE_READ = 5'b00001;
  localparam logic [CODE_W-1:0] CODE_STAT = 5'b00010;
  localparam logic [CODE_W-1:0] CODE_WCTL = 5'b00011;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_STAT, OP_WCTL} op_e;

  function automatic op_e decode_op(input logic [CODE_W-1:0] code);
    case (code)
      CODE_READ: return OP_READ;
      CODE_STAT: return OP_STAT;
      CODE_WCTL: return OP_WCTL;
      default:   return OP_NONE;
    endcase
  endfunction

  // Data bits stay in place; the label byte is mirrored unless rev is set.
  function automatic logic [WORD_W-1:0] map_word(input logic [WORD_W-1:0] w,
                                                 input logic rev);
    logic [WORD_W-1:0] o;
    o = w;
    for (int j = 0; j < LBL_W; j++) begin
      o[j] = rev ? w[j] : w[LBL_W-1-j];
    end
    return o;
  endfunction
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rd_cmd.sv
module spi_rd_cmd
  import spi_rd_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_rise,
  input  logic              si_s,
  input  logic [WORD_W-1:0] ch_word [N_CH],
  input  logic [N_CH-1:0]   ch_empty,
  input  logic [N_CH-1:0]   ch_flag,
  output logic [N_CH-1:0]   ch_pop,
  output logic              ctrl_rev,
  output logic              load_q,
  output logic [WORD_W-1:0] payload_q
);
  localparam int CNT_MAX = 2*OP_W + WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]    rcnt;
  logic [OP_W-1:0]     sh, sh_nxt;
  op_e                 op_q, op_dec;
  logic [CH_SEL_W-1:0] ch_q, sel;
  logic                empty_q, sel_empty;
  logic [WORD_W-1:0]   sel_word, payload_d;

  // named internal events
  logic decode_evt, done_evt, wctl_evt, live_rise;

  assign sh_nxt    = {sh[OP_W-2:0], si_s};
  assign sel       = sh_nxt[CH_SEL_W-1:0];
  assign op_dec    = decode_op(sh_nxt[OP_W-1:CH_SEL_W]);
  assign live_rise = !cs_n_s && sck_rise;

  assign decode_evt = live_rise && (rcnt == CNT_W'(OP_W-1));
  assign done_evt   = live_rise && (rcnt == CNT_W'(OP_W+WORD_W-1)) &&
                      (op_q == OP_READ) && !empty_q;
  assign wctl_evt   = live_rise && (rcnt == CNT_W'(2*OP_W-1)) && (op_q == OP_WCTL);

  always_comb begin
    sel_word  = '0;
    sel_empty = 1'b1;
    for (int i = 0; i < N_CH; i++) begin
      if (CH_SEL_W'(i) == sel) begin
        sel_word  = ch_word[i];
        sel_empty = ch_empty[i];
      end
    end
  end

  always_comb begin
    payload_d = '0;
    case (op_dec)
      OP_READ: payload_d = sel_empty ? '0 : map_word(sel_word, ctrl_rev);
      OP_STAT: payload_d[WORD_W-1 -: N_CH] = ch_flag;
      default: payload_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0; sh <= '0; op_q <= OP_NONE; ch_q <= '0;
      empty_q <= 1'b1; load_q <= 1'b0; payload_q <= '0;
    end else if (cs_n_s) begin
      rcnt <= '0; sh <= '0; op_q <= OP_NONE; ch_q <= '0;
      empty_q <= 1'b1; load_q <= 1'b0; payload_q <= '0;
    end else begin
      load_q <= decode_evt;
      if (sck_rise) begin
        sh <= sh_nxt;
        if (rcnt != CNT_W'(CNT_MAX)) rcnt <= rcnt + 1'b1;
      end
      if (decode_evt) begin
        op_q      <= op_dec;
        ch_q      <= sel;
        empty_q   <= sel_empty;
        payload_q <= payload_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ch_pop <= '0;
    else if (done_evt) ch_pop <= N_CH'(1) << ch_q;
    else               ch_pop <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_rev <= 1'b0;
    else if (wctl_evt) ctrl_rev <= sh_nxt[CTRL_REV_BIT];
  end

  AST_POP_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_pop));                    // R7
  AST_POP_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) (ch_pop != '0) |=> (ch_pop == '0));   // R7
  AST_IDLE_NO_POP:  assert property (@(posedge clk) disable iff (!rst_n) (cs_n_s && $past(cs_n_s)) |-> (ch_pop == '0)); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ((ch_pop & ch_empty) == '0));         // R8
  AST_CTRL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) cs_n_s |=> $stable(ctrl_rev));         // R9
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  output logic              tx_bit
);
  logic [WORD_W-1:0] sh;
  logic              pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; pend <= 1'b0;
    end else if (cs_n_s) begin
      sh <= '0; pend <= 1'b0;
    end else begin
      if (load) pend <= 1'b1;
      if (sck_fall) begin
        if (pend || load) begin
          sh   <= data;
          pend <= 1'b0;
        end else begin
          sh <= {sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign tx_bit = sh[WORD_W-1];

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_n_s |=> !tx_bit); // R1
endmodule

// File: rtl/spi_word_reader.sv
module spi_word_reader
  import spi_rd_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_si,
  output logic                     spi_so,
  output logic                     spi_so_oe,
  input  logic [N_CH*WORD_W-1:0]   ch_rd_data,
  input  logic [N_CH-1:0]          ch_empty,
  input  logic [N_CH-1:0]          ch_flag,
  output logic [N_CH-1:0]          ch_pop,
  output logic                     flag_any
);
  logic [2:0]        pins_s;
  logic              cs_n_s, sck_s, si_s, sck_d;
  logic              sck_rise, sck_fall;
  logic              ctrl_rev, load_q, tx_bit;
  logic [WORD_W-1:0] payload_q;
  logic [WORD_W-1:0] ch_word [N_CH];

  spi_rd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_si}), .q(pins_s)
  );
  assign {cs_n_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_word[i] = ch_rd_data[i*WORD_W +: WORD_W];
  end

  spi_rd_cmd #(.N_CH(N_CH)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_rise(sck_rise), .si_s(si_s),
    .ch_word(ch_word), .ch_empty(ch_empty), .ch_flag(ch_flag), .ch_pop(ch_pop),
    .ctrl_rev(ctrl_rev), .load_q(load_q), .payload_q(payload_q)
  );

  spi_rd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_fall(sck_fall),
    .load(load_q), .data(payload_q), .tx_bit(tx_bit)
  );

  assign spi_so_oe = ~cs_n_s;
  assign spi_so    = spi_so_oe & tx_bit;
  assign flag_any  = |ch_flag;
endmodule

// File: tb/spi_word_reader_tb.sv
module spi_word_reader_tb;
  localparam int N_CH = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 4-unit period: 250 MHz

  logic rst_n = 1'b0, spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
  wire  spi_so, spi_so_oe, flag_any;
  wire  [N_CH-1:0] ch_pop;
  logic [N_CH*32-1:0] ch_data = '0;
  logic [N_CH-1:0] ch_empty = '1, ch_flag = '0;

  spi_word_reader u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .ch_rd_data(ch_data), .ch_empty(ch_empty),
    .ch_flag(ch_flag), .ch_pop(ch_pop), .flag_any(flag_any)
  );

  // channel queue model
  logic [31:0] q [N_CH][$];
  int pops [N_CH];
  logic push_req = 1'b0;
  int push_ch = 0;
  logic [31:0] push_val = '0;
  int k_cmp = 0, k_mm = 0, e_cmp = 0, e_mm = 0, n_cmp = 0, n_mm = 0;
  logic p1 = 1'b1, p2 = 1'b1;

  initial for (int i = 0; i < N_CH; i++) pops[i] = 0;

  always @(posedge clk) begin
    for (int i = 0; i < N_CH; i++) begin
      if (ch_pop[i]) begin
        pops[i]++;
        k_cmp++;
        if (q[i].size() == 0) begin
          k_mm++;
          $display("FAIL R8 pop of empty channel %0d act=1 exp=0", i);
        end else void'(q[i].pop_front());
      end
    end
    if (push_req) q[push_ch].push_back(push_val);
    for (int i = 0; i < N_CH; i++) begin
      ch_data[i*32 +: 32] <= (q[i].size() != 0) ? q[i][0] : 32'h0;
      ch_empty[i]         <= (q[i].size() == 0);
    end
    p1 <= spi_cs_n;
    p2 <= p1;
  end

  // per-clock comparison of enable, idle SO and global flag
  always @(negedge clk) begin
    if (rst_n) begin
      e_cmp++;
      if (spi_so_oe !== !p2) begin
        e_mm++; $display("FAIL R1 so_oe act=%b exp=%b", spi_so_oe, !p2);
      end
      if (!spi_so_oe && spi_so !== 1'b0) begin
        e_mm++; $display("FAIL R1 idle so act=%b exp=0", spi_so);
      end
      if (flag_any !== |ch_flag) begin
        e_mm++; $display("FAIL R6 flag_any act=%b exp=%b", flag_any, |ch_flag);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mm++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_map(input logic [31:0] w, input logic rev);
    logic [31:0] e;
    for (int p = 1; p <= 32; p++) begin
      int a;
      a = (p <= 24 || rev) ? 33 - p : p - 24;
      e[32-p] = w[a-1];
    end
    return e;
  endfunction

  task automatic push(input int c, input logic [31:0] v);
    @(negedge clk);
    push_ch = c; push_val = v; push_req = 1'b1;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_si = b;
    repeat (HALF) @(negedge clk);
    r = spi_so;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] opc, input logic [31:0] dout, input int nbits,
                      output logic [31:0] rx);
    logic r;
    rx = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) spi_bit(opc[i], r);
    for (int i = 0; i < nbits; i++) begin
      spi_bit(dout[31-i], r);
      rx = {rx[30:0], r};
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_si = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  function automatic logic [7:0] opc(input logic [4:0] code, input int ch);
    return {code, 3'(ch)};
  endfunction

  localparam logic [4:0] C_RD = 5'b00001, C_ST = 5'b00010, C_WC = 5'b00011, C_BAD = 5'b11111;

  logic done = 1'b0;

  initial begin
    logic [31:0] rx;
    int exp_p2, exp_p3, exp_p5;
    repeat (3) @(negedge clk);
    chk("R1 reset so_oe", 32'(spi_so_oe), 0);
    chk("R6 reset flag_any", 32'(flag_any), 0);
    chk("R7 reset ch_pop", 32'(ch_pop), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 explicit
    ch_flag = 8'h10; #1;
    chk("R6 single flag", 32'(flag_any), 1);
    ch_flag = 8'h00; #1;
    chk("R6 no flag", 32'(flag_any), 0);

    // R2 R3 R4 R7: read ch2 with label order 0
    push(2, 32'hA5C3_0F81);
    push(5, 32'h1234_56C7);
    push(5, 32'hFEDC_BA3E);
    xfer(opc(C_RD, 2), 0, 32, rx);
    chk("R2/R3/R4 read ch2 normal label", rx, exp_map(32'hA5C3_0F81, 1'b0));
    chk("R7 ch2 popped once", pops[2], 1);
    chk("R7 ch5 untouched", pops[5], 0);

    // R9 write control, then R5 reversed label
    xfer(opc(C_WC, 0), 32'h0100_0000, 8, rx);
    xfer(opc(C_RD, 5), 0, 32, rx);
    chk("R5 read ch5 reversed label", rx, exp_map(32'h1234_56C7, 1'b1));
    chk("R7 ch5 pop", pops[5], 1);

    // R9 aborted write leaves bit at 1
    xfer(opc(C_WC, 0), 32'h0000_0000, 4, rx);
    xfer(opc(C_RD, 5), 0, 32, rx);
    chk("R9 aborted write keeps reversed", rx, exp_map(32'hFEDC_BA3E, 1'b1));
    chk("R7 ch5 second pop", pops[5], 2);

    // R8 empty read
    xfer(opc(C_RD, 5), 0, 32, rx);
    chk("R8 empty read zeros", rx, 0);
    chk("R8 empty read no pop", pops[5], 2);

    // R9 write back to 0
    xfer(opc(C_WC, 0), 32'h0000_0000, 8, rx);

    // R7 early chip-select rise
    push(3, 32'h8000_00FF);
    xfer(opc(C_RD, 3), 0, 20, rx);
    chk("R7 partial read no pop", pops[3], 0);
    xfer(opc(C_RD, 3), 0, 32, rx);
    chk("R9/R4 read ch3 after clearing bit", rx, exp_map(32'h8000_00FF, 1'b0));
    chk("R7 ch3 pop after full read", pops[3], 1);

    // R10 status
    ch_flag = 8'hA5;
    xfer(opc(C_ST, 0), 0, 8, rx);
    chk("R10 status byte", rx, 32'h0000_00A5);
    ch_flag = 8'h3C;
    xfer(opc(C_ST, 6), 0, 8, rx);
    chk("R10 status byte 2", rx, 32'h0000_003C);
    ch_flag = 8'h00;

    // R11 unknown opcode
    push(7, 32'h0F0F_1B2D);
    push(7, 32'hC001_D00D);
    xfer(opc(C_BAD, 7), 0, 32, rx);
    chk("R11 unknown op returns zeros", rx, 0);
    chk("R11 unknown op no pop", pops[7], 0);
    xfer(opc(C_RD, 7), 0, 32, rx);
    chk("R11/R4 word intact, order unchanged", rx, exp_map(32'h0F0F_1B2D, 1'b0));
    xfer(opc(C_RD, 7), 0, 32, rx);
    chk("R3 back-to-back ch7", rx, exp_map(32'hC001_D00D, 1'b0));
    chk("R7 ch7 two pops", pops[7], 2);

    // channel 0 edge
    push(0, 32'hFFFF_FF01);
    xfer(opc(C_RD, 0), 0, 32, rx);
    chk("R2/R4 read ch0", rx, exp_map(32'hFFFF_FF01, 1'b0));
    chk("R7 ch0 pop", pops[0], 1);
    exp_p2 = 1; exp_p3 = 1; exp_p5 = 2;
    chk("R7 final ch2 pops", pops[2], exp_p2);
    chk("R7 final ch3 pops", pops[3], exp_p3);
    chk("R7 final ch5 pops", pops[5], exp_p5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_cmp + k_cmp + e_cmp, n_mm + k_mm + e_mm);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               n_cmp + k_cmp + e_cmp + 1, n_mm + k_mm + e_mm + 1);
      $finish;
    end
  end
endmodule